// File: doc/BRIEF.md
# Page Program Data Buffer

This block sits between a serial flash command front end and the flash array. During a page program command it gathers the incoming data bytes into a page-sized holding store. It records the byte position each byte belongs to, starting from the low bits of the command's start address. A per-byte valid mask records which positions were written. When the command ends, the front end reports the chip-select rise, whether it landed exactly on a byte boundary, and whether protection allows the program. If all three conditions favour a commit and at least one byte arrived, the buffer walks the mask from the lowest offset up. For each valid byte it first issues a read beat and then a write beat carrying the old contents ANDed with the new byte, so bits can only go from 1 to 0. If the command is aborted, no beat is ever issued.

States: `IDLE` (waiting for a command), `COLLECT` (storing bytes), `SCAN` (locate the next valid offset and issue its read beat), `MERGE` (issue the write beat), `FINISH` (one-cycle done pulse). Transitions: `IDLE→COLLECT` on command start, which also clears the mask and loads the offset. `COLLECT→SCAN` on a chip-select rise that is on a boundary, with permit high and at least one byte received. `COLLECT→IDLE` on any other chip-select rise. `SCAN→MERGE` when a valid offset exists. `SCAN→FINISH` when none remains. `MERGE→SCAN` when another valid offset lies above the current one, and `MERGE→FINISH` otherwise. `FINISH→IDLE` always.

Top module: `pp_page_buffer`

## Requirements
- R1: Every array beat of a commit addresses the page of the command's start address, whose base is that address with its low PAGE_BITS (default 8) bits cleared.
- R2: Data bytes are stored at consecutive offsets starting at the start address's low bits; past offset 255 they continue at offset 0 of the same page.
- R3: When more than 256 bytes arrive, each offset holds the last byte received for it, so the last 256 bytes are the ones programmed.
- R4: Offsets that received no byte in the command are neither read nor written, and their array contents stay unchanged.
- R5: Each written byte equals the array's old value ANDed with the buffered byte.
- R6: A command that ends with no data byte received produces no array beat and no done pulse.
- R7: A command whose chip-select rise is not on a byte boundary (cs_on_boundary=0) produces no array beat.
- R8: A command whose chip-select rise arrives with wr_permit=0 produces no array beat.
- R9: A commit emits exactly one write beat per valid offset, in strictly ascending address order.
- R10: Each write beat comes one cycle after a read beat to the same address. The array returns read data one cycle after arr_rd_en.
- R11: done is a single-cycle pulse in the cycle right after the last write beat.
- R12: The mask is cleared at each command start, so bytes from an earlier aborted command are never programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a page program command begins |
| start_addr | input | ADDR_W | Start address of the command, valid with cmd_start |
| byte_valid | input | 1 | One data byte is present this cycle |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip select has risen, command ends |
| cs_on_boundary | input | 1 | With cs_rise: the rise followed the 8th bit of a byte |
| wr_permit | input | 1 | With cs_rise: protection allows programming the page |
| arr_rd_en | output | 1 | Read beat toward the array |
| arr_wr_en | output | 1 | Write beat toward the array |
| arr_addr | output | ADDR_W | Address of the current beat |
| arr_wdata | output | 8 | Write data (old AND new) |
| arr_rdata | input | 8 | Array read data, one cycle after arr_rd_en |
| done | output | 1 | Pulse: commit complete |

## Verification
After a chip-select rise that leads to a commit, the first read beat appears in the next cycle. Its write beat follows one cycle later, and done follows one cycle after the final write. An aborted command leaves the block idle in the next cycle. The bench samples every output on the falling clock edge, midway between the edges where the state changes. It pairs each write beat with the read beat seen on the previous falling edge, so each result is checked in exactly the cycle it is due. Array contents are compared only after done or after a fixed idle wait, once no beat can still be pending.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_SCAN    = 3'd2,
        ST_MERGE   = 3'd3,
        ST_FINISH  = 3'd4
    } pp_state_e;
endpackage

// File: rtl/pp_byte_store.sv
module pp_byte_store #(
    parameter int PAGE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [PAGE_BITS-1:0] load_ofs,
    input  logic                 wr_en,
    input  logic [7:0]           wr_byte,
    input  logic [PAGE_BITS-1:0] rd_ofs,
    output logic [7:0]           rd_byte,
    output logic [(1<<PAGE_BITS)-1:0] valid_mask
);
    localparam int PAGE = 1 << PAGE_BITS;

    logic [7:0]           slots [PAGE];
    logic [PAGE_BITS-1:0] put_ofs;

    // Write pointer wraps naturally at the page end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            put_ofs    <= '0;
            valid_mask <= '0;
        end else if (clear) begin
            put_ofs    <= load_ofs;
            valid_mask <= '0;
        end else if (wr_en) begin
            put_ofs             <= put_ofs + 1'b1;
            valid_mask[put_ofs] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            slots[put_ofs] <= wr_byte;
        end
    end

    assign rd_byte = slots[rd_ofs];
endmodule

// File: rtl/pp_valid_scan.sv
module pp_valid_scan #(
    parameter int PAGE_BITS = 8
) (
    input  logic [(1<<PAGE_BITS)-1:0] valid_mask,
    input  logic [PAGE_BITS:0]        from_ofs,
    output logic                      found,
    output logic [PAGE_BITS-1:0]      hit_ofs
);
    localparam int PAGE = 1 << PAGE_BITS;

    // Lowest set mask bit at or above from_ofs; from_ofs >= PAGE finds nothing.
    always_comb begin
        found   = 1'b0;
        hit_ofs = '0;
        for (int i = PAGE - 1; i >= 0; i--) begin
            if (valid_mask[i] && (i >= int'(from_ofs))) begin
                found   = 1'b1;
                hit_ofs = PAGE_BITS'(i);
            end
        end
    end
endmodule

// File: rtl/pp_page_buffer.sv
module pp_page_buffer
    import pp_buf_pkg::*;
#(
    parameter int PAGE_BITS = 8,
    parameter int ADDR_W    = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_on_boundary,
    input  logic              wr_permit,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata,
    output logic              done
);
    localparam int PAGE   = 1 << PAGE_BITS;
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    pp_state_e            state, state_nx;
    logic [PAGE_W-1:0]    page_q;
    logic [PAGE_BITS:0]   cursor_q;
    logic [PAGE_BITS-1:0] cur_q;
    logic [PAGE-1:0]      mask;
    logic                 found;
    logic [PAGE_BITS-1:0] hit_ofs;
    logic [7:0]           buf_byte;
    logic                 store_clear;
    logic                 store_wr;

    assign store_clear = (state == ST_IDLE) && cmd_start;
    assign store_wr    = (state == ST_COLLECT) && byte_valid && !cs_rise;

    pp_byte_store #(.PAGE_BITS(PAGE_BITS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (store_clear),
        .load_ofs   (start_addr[PAGE_BITS-1:0]),
        .wr_en      (store_wr),
        .wr_byte    (byte_data),
        .rd_ofs     (cur_q),
        .rd_byte    (buf_byte),
        .valid_mask (mask)
    );

    pp_valid_scan #(.PAGE_BITS(PAGE_BITS)) u_scan (
        .valid_mask (mask),
        .from_ofs   (cursor_q),
        .found      (found),
        .hit_ofs    (hit_ofs)
    );

    // Next-state decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cmd_start) state_nx = ST_COLLECT;
            ST_COLLECT: begin
                if (cs_rise) begin
                    if (cs_on_boundary && wr_permit && (|mask)) state_nx = ST_SCAN;
                    else                                        state_nx = ST_IDLE;
                end
            end
            ST_SCAN:    state_nx = found ? ST_MERGE : ST_FINISH;
            ST_MERGE:   state_nx = found ? ST_SCAN : ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and walk bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            page_q   <= '0;
            cursor_q <= '0;
            cur_q    <= '0;
        end else begin
            state <= state_nx;
            if (store_clear) begin
                page_q   <= start_addr[ADDR_W-1:PAGE_BITS];
                cursor_q <= '0;
            end
            if (state == ST_SCAN && found) begin
                cur_q    <= hit_ofs;
                cursor_q <= {1'b0, hit_ofs} + 1'b1;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        arr_rd_en = 1'b0;
        arr_wr_en = 1'b0;
        arr_addr  = {page_q, cur_q};
        arr_wdata = 8'h00;
        done      = 1'b0;
        unique case (state)
            ST_SCAN: begin
                arr_rd_en = found;
                arr_addr  = {page_q, hit_ofs};
            end
            ST_MERGE: begin
                arr_wr_en = 1'b1;
                arr_wdata = arr_rdata & buf_byte;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pp_page_buffer_chk.sv
module pp_page_buffer_chk #(
    parameter int PAGE_BITS = 8,
    parameter int ADDR_W    = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              arr_rd_en,
    input logic              arr_wr_en,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              done
);
    logic [ADDR_W-PAGE_BITS-1:0] page_seen;
    logic [ADDR_W-1:0]           last_wr;
    logic                        have_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_seen <= '0;
            last_wr   <= '0;
            have_wr   <= 1'b0;
        end else begin
            if (cmd_start && !arr_rd_en && !arr_wr_en) page_seen <= start_addr[ADDR_W-1:PAGE_BITS];
            if (done) have_wr <= 1'b0;
            else if (arr_wr_en) begin
                have_wr <= 1'b1;
                last_wr <= arr_addr;
            end
        end
    end

    // R1
    page_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_wr_en) |-> arr_addr[ADDR_W-1:PAGE_BITS] == page_seen);

    // R9
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && have_wr) |-> arr_addr > last_wr);

    // R10
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> ($past(arr_rd_en) && $past(arr_addr) == arr_addr));

    // R11
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(arr_wr_en));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    beat_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd_en, arr_wr_en, done}));
endmodule

bind pp_page_buffer pp_page_buffer_chk #(.PAGE_BITS(PAGE_BITS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .start_addr (start_addr),
    .arr_rd_en  (arr_rd_en),
    .arr_wr_en  (arr_wr_en),
    .arr_addr   (arr_addr),
    .done       (done)
);

// File: tb/pp_page_buffer_tb.sv
module pp_page_buffer_tb;
    localparam int PB  = 8;
    localparam int AW  = 10;
    localparam int MEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          cs_on_boundary = 1'b0;
    logic          wr_permit = 1'b0;
    logic          arr_rd_en, arr_wr_en, done;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;
    logic [7:0]    arr_rdata;

    logic [7:0] amem [MEM];
    logic [7:0] emem [MEM];

    int checks = 0;
    int fails  = 0;
    int beats, order_err, pair_err, done_cnt, done_err;
    logic          prev_rd, prev_wr, have_last;
    logic [AW-1:0] prev_addr, last_addr;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    pp_page_buffer #(.PAGE_BITS(PB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_on_boundary(cs_on_boundary), .wr_permit(wr_permit),
        .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .done(done)
    );

    // Array model: one-cycle read latency.
    always @(posedge clk) begin
        if (arr_rd_en) arr_rdata <= amem[arr_addr];
        if (arr_wr_en) amem[arr_addr] <= arr_wdata;
    end

    // Beat monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (arr_wr_en) begin
            beats++;
            if (!(prev_rd && prev_addr == arr_addr)) pair_err++;
            if (have_last && arr_addr <= last_addr) order_err++;
            have_last = 1'b1;
            last_addr = arr_addr;
        end
        if (done) begin
            done_cnt++;
            if (!prev_wr) done_err++;
        end
        prev_rd   = arr_rd_en;
        prev_wr   = arr_wr_en;
        prev_addr = arr_addr;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_array(input int seed);
        for (int a = 0; a < MEM; a++) begin
            amem[a] = 8'((a * 29 + seed * 13) ^ 8'hF3);
            emem[a] = amem[a];
        end
    endtask

    task automatic clear_mon();
        beats = 0; order_err = 0; pair_err = 0; done_cnt = 0; done_err = 0;
        have_last = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11) ^ 8'hA5);
    endfunction

    // Runs one command; the model is updated only when a commit is due.
    task automatic run_cmd(input int page, input int ofs, input int len, input int seed,
                           input bit bnd, input bit perm, input string req);
        logic [7:0] nb [1<<PB];
        bit         sent [1<<PB];
        bit         commit;
        int         nsent;
        int         waited;
        for (int k = 0; k < (1 << PB); k++) begin
            sent[k] = 1'b0;
            nb[k]   = 8'h00;
        end
        nsent = 0;
        for (int i = 0; i < len; i++) begin
            int o = (ofs + i) % (1 << PB);
            if (!sent[o]) nsent++;
            sent[o] = 1'b1;
            nb[o]   = pat(i, seed);
        end
        commit = bnd && perm && (len > 0);
        clear_mon();
        @(negedge clk);
        cmd_start  = 1'b1;
        start_addr = AW'((page << PB) + ofs);
        @(negedge clk);
        cmd_start  = 1'b0;
        for (int i = 0; i < len; i++) begin
            byte_valid = 1'b1;
            byte_data  = pat(i, seed);
            @(negedge clk);
        end
        byte_valid     = 1'b0;
        cs_rise        = 1'b1;
        cs_on_boundary = bnd;
        wr_permit      = perm;
        @(negedge clk);
        cs_rise = 1'b0;
        waited  = 0;
        if (commit) begin
            while (done_cnt == 0 && waited < 2000) begin
                @(negedge clk);
                waited++;
            end
            for (int k = 0; k < (1 << PB); k++)
                if (sent[k]) emem[(page << PB) + k] = emem[(page << PB) + k] & nb[k];
        end else begin
            repeat (8) @(negedge clk);
        end
        begin
            int bad = 0;
            int first_bad = 0;
            for (int a = 0; a < MEM; a++)
                if (amem[a] !== emem[a]) begin
                    if (bad == 0) first_bad = a;
                    bad++;
                end
            check(bad == 0, req, bad == 0 ? 0 : int'(amem[first_bad]),
                  bad == 0 ? 0 : int'(emem[first_bad]));
        end
        check(beats == (commit ? nsent : 0), {req, " R9 beat count"}, beats, commit ? nsent : 0);
        check(order_err == 0, {req, " R9 order"}, order_err, 0);
        check(pair_err == 0, {req, " R10 read/write pairing"}, pair_err, 0);
        check(done_cnt == (commit ? 1 : 0) && done_err == 0, {req, " R11 done"},
              done_cnt, commit ? 1 : 0);
    endtask

    initial begin
        fill_array(0);
        clear_mon();
        prev_rd = 1'b0; prev_wr = 1'b0; prev_addr = '0; last_addr = '0;
        arr_rdata = 8'h00;
        repeat (3) @(negedge clk);
        check(!arr_rd_en && !arr_wr_en && !done, "reset outputs idle",
              int'({arr_rd_en, arr_wr_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!arr_rd_en && !arr_wr_en && !done, "idle after reset",
              int'({arr_rd_en, arr_wr_en, done}), 0);

        // Sweep of start offsets and lengths: R1 R2 R3 R4 R5
        begin
            int ofsl [4] = '{0, 1, 128, 255};
            int lenl [8] = '{1, 2, 3, 255, 256, 257, 511, 600};
            int n = 0;
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 8; b++) begin
                    fill_array(n);
                    run_cmd(n % 4, ofsl[a], lenl[b], n, 1'b1, 1'b1, "R1 R2 R3 R4 R5 sweep");
                    n++;
                end
        end

        // R6: no data byte
        fill_array(40);
        run_cmd(2, 17, 0, 40, 1'b1, 1'b1, "R6 empty command");
        // R7: off-boundary chip-select rise
        fill_array(41);
        run_cmd(1, 5, 20, 41, 1'b0, 1'b1, "R7 bad boundary");
        // R8: no permit
        fill_array(42);
        run_cmd(3, 250, 300, 42, 1'b1, 1'b0, "R8 not permitted");
        // R12: aborted full page, then a single-byte commit
        fill_array(43);
        run_cmd(0, 0, 256, 43, 1'b1, 1'b0, "R12 aborted fill");
        run_cmd(0, 77, 1, 44, 1'b1, 1'b1, "R12 single byte after abort");
        // R5: repeated AND onto same bytes
        run_cmd(0, 70, 16, 45, 1'b1, 1'b1, "R5 second program same page");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule